// File: doc/BRIEF.md
# Configuration Header Target with Sizable Base Address Registers

This block is the configuration-space target of one bus device. It holds a 256-byte header: 64 dwords that a configuration port reads and writes one 32-bit dword at a time. Reads are combinational from the dword index. Writes take effect on the next rising clock edge and follow the four byte enables.

The header carries the identity fields, a command register, the class and revision codes, an interrupt routing byte with a fixed pin byte, and two base address registers (BARs). Each BAR has a fixed power-of-two size and a fixed space type. Software finds the size by writing all ones and reading the register back. It then programs a naturally aligned base.

From the programmed bases and the command enables, the block decodes incoming request addresses into per-BAR, memory and I/O hit signals. A `present_i` input set low makes the device look like an empty slot.

Top module: `cfg_hdr_target`

## Requirements
- R1: Dword 0 reads {device ID in bits 31:16, vendor ID in bits 15:0} (defaults 0x0A51 and 0x1D0C), and writes to it have no effect.
- R2: Dword 2 reads {class code in bits 31:8, revision in bits 7:0}. The defaults are class 0x060400 (bridge) and revision 0x01. The dword is read-only.
- R3: Dword 1 holds the command field. Bit 0 enables I/O decode and bit 1 enables memory decode. All other bits read 0, and both enables reset to 0. A write changes them only when byte enable 0 is set.
- R4: The memory BAR at dword 4 always reads 0 in bits 3:0, meaning 32-bit and non-prefetchable. The I/O BAR at dword 5 always reads 1 in bit 0 and 0 in bit 1.
- R5: Address bits below a BAR's size always read 0. With the defaults (4 KiB memory, 256-byte I/O), writing 0xFFFFFFFF reads back 0xFFFFF000 and 0xFFFFFF01. Both BARs reset to a base of 0.
- R6: A BAR write updates only the byte lanes whose byte enable is set.
- R7: A request with `req_io_i`=0 hits the memory BAR when its address bits 31:12 equal the programmed base and the memory enable is set. A hit raises `bar_hit_o[0]` and `mem_hit_o` in the same cycle.
- R8: A request with `req_io_i`=1 hits the I/O BAR when its address bits 31:8 equal the programmed base and the I/O enable is set. A hit raises `bar_hit_o[1]` and `io_hit_o`.
- R9: No hit is produced while the matching enable is clear, when the request space differs from the BAR type, or when the address lies outside the region.
- R10: Byte 0 of dword 15 is a writable interrupt line that resets to 0. Byte 1 is the interrupt pin, fixed at 1 (pin A), and ignores writes.
- R11: While `present_i` is low, every read returns 0xFFFFFFFF and writes change nothing.
- R12: Unimplemented dwords (for example dword 3) read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| present_i | input | 1 | Device present; low emulates an empty slot |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_dw_addr_i | input | 6 | Dword index into the header |
| cfg_be_i | input | 4 | Byte enables for writes |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for the addressed dword |
| req_addr_i | input | 32 | Incoming request address to decode |
| req_io_i | input | 1 | Request space: 1 I/O, 0 memory |
| bar_hit_o | output | 2 | Per-BAR hit |
| mem_hit_o | output | 1 | Any memory BAR hit |
| io_hit_o | output | 1 | Any I/O BAR hit |

## Verification
The decoder is driven with addresses at the start and the last byte of each programmed region, and with the first address past each region, which separates correct from off-by-one masking. The same in-region addresses are repeated with decode disabled and with the other request space, which tells enable gating and type matching apart from the address compare. The all-ones sizing writes, the partial byte-enable writes and the writes to read-only or unimplemented dwords show which bits the header keeps and which it drops. Reads with the device absent, followed by a read once it is present again, show that an absent device neither answers nor accepts writes.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int unsigned HDR_BYTES   = 256;
  localparam int unsigned DW_ADDR_W   = $clog2(HDR_BYTES / 4);
  localparam int unsigned NUM_BAR     = 2;
  localparam int unsigned DW_ID       = 0;
  localparam int unsigned DW_CMD      = 1;
  localparam int unsigned DW_CLASS    = 2;
  localparam int unsigned DW_BAR_BASE = 4;
  localparam int unsigned DW_INTR     = 15;

  typedef struct packed {
    logic mem_en;
    logic io_en;
  } cmd_t;
endpackage

// File: rtl/cfg_bar.sv
module cfg_bar #(
  parameter bit          IS_IO   = 1'b0,
  parameter int unsigned SZ_LOG2 = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        dec_en_i,
  input  logic [31:0] req_addr_i,
  input  logic        req_io_i,
  output logic        hit_o
);
  localparam logic [31:0] BASE_MASK = ~((32'd1 << SZ_LOG2) - 32'd1);
  localparam logic [31:0] TYPE_BITS = IS_IO ? 32'd1 : 32'd0;

  logic [31:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (wr_i) begin
      for (int b = 0; b < 4; b++) begin
        if (be_i[b]) base_q[8*b +: 8] <= wdata_i[8*b +: 8] & BASE_MASK[8*b +: 8];
      end
    end
  end

  assign rdata_o = base_q | TYPE_BITS;
  assign hit_o   = dec_en_i && (req_io_i == IS_IO) && ((req_addr_i & BASE_MASK) == base_q);
endmodule

// File: rtl/cfg_ctl_regs.sv
module cfg_ctl_regs
  import cfg_hdr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_wr_i,
  input  logic       intr_wr_i,
  input  logic       be0_i,
  input  logic [7:0] wdata_i,
  output cmd_t       cmd_o,
  output logic [7:0] int_line_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o      <= '0;
      int_line_o <= '0;
    end else begin
      if (cmd_wr_i && be0_i) begin
        cmd_o.io_en  <= wdata_i[0];
        cmd_o.mem_en <= wdata_i[1];
      end
      if (intr_wr_i && be0_i) int_line_o <= wdata_i;
    end
  end
endmodule

// File: rtl/cfg_hdr_target.sv
module cfg_hdr_target
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1D0C,
  parameter logic [15:0] DEVICE_ID  = 16'h0A51,
  parameter logic [7:0]  REV_ID     = 8'h01,
  parameter logic [23:0] CLASS_CODE = 24'h060400,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [NUM_BAR-1:0] BAR_IS_IO = 2'b10,
  parameter int unsigned BAR_SZ_LOG2 [NUM_BAR] = '{12, 8}
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 present_i,
  input  logic                 cfg_wr_i,
  input  logic [DW_ADDR_W-1:0] cfg_dw_addr_i,
  input  logic [3:0]           cfg_be_i,
  input  logic [31:0]          cfg_wdata_i,
  output logic [31:0]          cfg_rdata_o,
  input  logic [31:0]          req_addr_i,
  input  logic                 req_io_i,
  output logic [NUM_BAR-1:0]   bar_hit_o,
  output logic                 mem_hit_o,
  output logic                 io_hit_o
);
  logic        wr_ok;
  cmd_t        cmd;
  logic [7:0]  int_line;
  logic [31:0] bar_rdata [NUM_BAR];

  assign wr_ok = cfg_wr_i && present_i;

  cfg_ctl_regs u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_wr_i   (wr_ok && (cfg_dw_addr_i == DW_ADDR_W'(DW_CMD))),
    .intr_wr_i  (wr_ok && (cfg_dw_addr_i == DW_ADDR_W'(DW_INTR))),
    .be0_i      (cfg_be_i[0]),
    .wdata_i    (cfg_wdata_i[7:0]),
    .cmd_o      (cmd),
    .int_line_o (int_line)
  );

  for (genvar g = 0; g < NUM_BAR; g++) begin : g_bar
    cfg_bar #(
      .IS_IO   (BAR_IS_IO[g]),
      .SZ_LOG2 (BAR_SZ_LOG2[g])
    ) u_bar (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_ok && (cfg_dw_addr_i == DW_ADDR_W'(DW_BAR_BASE + g))),
      .be_i       (cfg_be_i),
      .wdata_i    (cfg_wdata_i),
      .rdata_o    (bar_rdata[g]),
      .dec_en_i   (BAR_IS_IO[g] ? cmd.io_en : cmd.mem_en),
      .req_addr_i (req_addr_i),
      .req_io_i   (req_io_i),
      .hit_o      (bar_hit_o[g])
    );
  end

  assign mem_hit_o = |(bar_hit_o & ~BAR_IS_IO);
  assign io_hit_o  = |(bar_hit_o & BAR_IS_IO);

  always_comb begin
    cfg_rdata_o = '0;
    if (!present_i) begin
      cfg_rdata_o = '1;
    end else begin
      if (cfg_dw_addr_i == DW_ADDR_W'(DW_ID))    cfg_rdata_o = {DEVICE_ID, VENDOR_ID};
      if (cfg_dw_addr_i == DW_ADDR_W'(DW_CMD))   cfg_rdata_o = {30'd0, cmd.mem_en, cmd.io_en};
      if (cfg_dw_addr_i == DW_ADDR_W'(DW_CLASS)) cfg_rdata_o = {CLASS_CODE, REV_ID};
      if (cfg_dw_addr_i == DW_ADDR_W'(DW_INTR))  cfg_rdata_o = {16'd0, INT_PIN, int_line};
      for (int g = 0; g < NUM_BAR; g++) begin
        if (cfg_dw_addr_i == DW_ADDR_W'(DW_BAR_BASE + g)) cfg_rdata_o = bar_rdata[g];
      end
    end
  end
endmodule

// File: rtl/cfg_hdr_checker.sv
module cfg_hdr_checker
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1D0C,
  parameter logic [15:0] DEVICE_ID = 16'h0A51,
  parameter logic [7:0]  INT_PIN   = 8'h01
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 present_i,
  input logic                 cfg_wr_i,
  input logic [DW_ADDR_W-1:0] cfg_dw_addr_i,
  input logic [31:0]          cfg_rdata_o,
  input logic [NUM_BAR-1:0]   bar_hit_o,
  input logic                 mem_hit_o,
  input logic                 io_hit_o,
  input logic                 mem_en_i,
  input logic                 io_en_i
);
  a_r11_absent_all_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !present_i |-> cfg_rdata_o == 32'hFFFF_FFFF);

  a_r1_id_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (present_i && cfg_dw_addr_i == DW_ADDR_W'(DW_ID)) |-> cfg_rdata_o == {DEVICE_ID, VENDOR_ID});

  a_r4_mem_bar_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (present_i && cfg_dw_addr_i == DW_ADDR_W'(DW_BAR_BASE)) |-> cfg_rdata_o[3:0] == 4'h0);

  a_r10_pin_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (present_i && cfg_dw_addr_i == DW_ADDR_W'(DW_INTR)) |-> cfg_rdata_o[15:8] == INT_PIN);

  a_r9_mem_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_en_i |-> !mem_hit_o);

  a_r9_io_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_en_i |-> !io_hit_o);

  a_r7_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bar_hit_o));

  a_r3_cmd_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_wr_i && present_i && cfg_dw_addr_i == DW_ADDR_W'(DW_CMD))
      |=> ($stable(mem_en_i) && $stable(io_en_i)));
endmodule

bind cfg_hdr_target cfg_hdr_checker #(
  .VENDOR_ID (VENDOR_ID),
  .DEVICE_ID (DEVICE_ID),
  .INT_PIN   (INT_PIN)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .present_i     (present_i),
  .cfg_wr_i      (cfg_wr_i),
  .cfg_dw_addr_i (cfg_dw_addr_i),
  .cfg_rdata_o   (cfg_rdata_o),
  .bar_hit_o     (bar_hit_o),
  .mem_hit_o     (mem_hit_o),
  .io_hit_o      (io_hit_o),
  .mem_en_i      (cmd.mem_en),
  .io_en_i       (cmd.io_en)
);

// File: tb/sim_cfg_hdr_target.sv
module sim_cfg_hdr_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        present = 1'b1;
  logic        wr = 1'b0;
  logic [5:0]  dw = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] req_addr = '0;
  logic        req_io = 1'b0;
  logic [1:0]  bar_hit;
  logic        mem_hit, io_hit;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cfg_hdr_target u0 (
    .clk_i(clk), .rst_ni(rst_n), .present_i(present),
    .cfg_wr_i(wr), .cfg_dw_addr_i(dw), .cfg_be_i(be), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .req_addr_i(req_addr), .req_io_i(req_io),
    .bar_hit_o(bar_hit), .mem_hit_o(mem_hit), .io_hit_o(io_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    dw = a; wdata = d; be = b; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; be = '0;
  endtask

  task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    dw = a;
    #1 d = rdata;
  endtask

  task automatic probe(input logic [31:0] a, input logic io, output logic [3:0] res);
    @(negedge clk);
    req_addr = a; req_io = io;
    #1 res = {bar_hit, mem_hit, io_hit};
  endtask

  task automatic t_reset;
    logic [31:0] d;
    cfg_read(6'd1, d);  check("R3 reset cmd", d, 32'h0);
    cfg_read(6'd4, d);  check("R5 reset mem bar", d, 32'h0);
    cfg_read(6'd5, d);  check("R5 reset io bar", d, 32'h1);
    cfg_read(6'd15, d); check("R10 reset intr", d, 32'h0000_0100);
  endtask

  task automatic t_ids;
    logic [31:0] d;
    cfg_write(6'd0, 32'h1234_5678, 4'hF);
    cfg_read(6'd0, d); check("R1 id ignores write", d, 32'h0A51_1D0C);
    cfg_write(6'd2, 32'hFFFF_FFFF, 4'hF);
    cfg_read(6'd2, d); check("R2 class/rev", d, 32'h0604_0001);
    cfg_write(6'd3, 32'hDEAD_BEEF, 4'hF);
    cfg_read(6'd3, d); check("R12 unimplemented", d, 32'h0);
  endtask

  task automatic t_sizing;
    logic [31:0] d;
    cfg_write(6'd4, 32'hFFFF_FFFF, 4'hF);
    cfg_read(6'd4, d); check("R5 R4 mem bar size", d, 32'hFFFF_F000);
    cfg_write(6'd5, 32'hFFFF_FFFF, 4'hF);
    cfg_read(6'd5, d); check("R5 R4 io bar size", d, 32'hFFFF_FF01);
    cfg_write(6'd4, 32'h4000_0000, 4'hF);
    cfg_write(6'd5, 32'h0000_1200, 4'hF);
    cfg_read(6'd4, d); check("R5 mem bar base", d, 32'h4000_0000);
    cfg_read(6'd5, d); check("R5 io bar base", d, 32'h0000_1201);
  endtask

  task automatic t_decode;
    logic [3:0]  h;
    logic [31:0] d;
    probe(32'h4000_0ABC, 1'b0, h); check("R9 mem hit off before enable", 32'(h), 32'h0);
    probe(32'h0000_1234, 1'b1, h); check("R9 io hit off before enable", 32'(h), 32'h0);
    cfg_write(6'd1, 32'h0000_0002, 4'h0);
    cfg_read(6'd1, d); check("R3 cmd needs be0", d, 32'h0);
    cfg_write(6'd1, 32'hFFFF_FFFE, 4'hF);
    cfg_read(6'd1, d); check("R3 mem enable only", d, 32'h2);
    probe(32'h4000_0000, 1'b0, h); check("R7 mem hit base", 32'(h), 32'b0110);
    probe(32'h4000_0FFF, 1'b0, h); check("R7 mem hit top", 32'(h), 32'b0110);
    probe(32'h4000_1000, 1'b0, h); check("R9 mem past end", 32'(h), 32'h0);
    probe(32'h4000_0ABC, 1'b1, h); check("R9 space mismatch", 32'(h), 32'h0);
    probe(32'h0000_1234, 1'b1, h); check("R9 io still off", 32'(h), 32'h0);
    cfg_write(6'd1, 32'h0000_0003, 4'h1);
    probe(32'h0000_1200, 1'b1, h); check("R8 io hit base", 32'(h), 32'b1001);
    probe(32'h0000_12FF, 1'b1, h); check("R8 io hit top", 32'(h), 32'b1001);
    probe(32'h0000_1300, 1'b1, h); check("R9 io past end", 32'(h), 32'h0);
    probe(32'h0000_1250, 1'b0, h); check("R9 io base as memory", 32'(h), 32'h0);
  endtask

  task automatic t_byte_lanes;
    logic [31:0] d;
    logic [3:0]  h;
    cfg_write(6'd4, 32'h7F12_3456, 4'b1000);
    cfg_read(6'd4, d); check("R6 top lane only", d, 32'h7F00_0000);
    probe(32'h7F00_0010, 1'b0, h); check("R7 hit after lane write", 32'(h), 32'b0110);
    cfg_write(6'd5, 32'h0000_AB00, 4'b0010);
    cfg_read(6'd5, d); check("R6 io lane1", d, 32'h0000_AB01);
  endtask

  task automatic t_intr;
    logic [31:0] d;
    cfg_write(6'd15, 32'h0000_070B, 4'h3);
    cfg_read(6'd15, d); check("R10 line written pin fixed", d, 32'h0000_010B);
    cfg_write(6'd15, 32'h0000_0022, 4'h2);
    cfg_read(6'd15, d); check("R10 line needs be0", d, 32'h0000_010B);
  endtask

  task automatic t_absent;
    logic [31:0] d;
    present = 1'b0;
    cfg_read(6'd0, d);  check("R11 absent id", d, 32'hFFFF_FFFF);
    cfg_read(6'd3, d);  check("R11 absent other", d, 32'hFFFF_FFFF);
    cfg_write(6'd1, 32'h0, 4'hF);
    cfg_write(6'd15, 32'h0000_0055, 4'hF);
    present = 1'b1;
    cfg_read(6'd1, d);  check("R11 absent write ignored cmd", d, 32'h3);
    cfg_read(6'd15, d); check("R11 absent write ignored line", d, 32'h0000_010B);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ids();
    t_sizing();
    t_decode();
    t_byte_lanes();
    t_intr();
    t_absent();
    finish_run();
  end
endmodule